// File: doc/BRIEF.md
# CPU Interrupt Acknowledge Interface

This block is the per-processor end of an interrupt controller. A distributor offers it one candidate at a time (an ID and an 8-bit priority, lower value meaning more urgent). The block decides whether that candidate may interrupt the processor, drives a registered active-high `irq` line, and gives software a small 32-bit register window. Through it, software takes an interrupt, reads the running and highest-pending status, and retires the interrupt when handling is complete. An acknowledge or a retirement is reported back to the distributor as a one-cycle strobe carrying the interrupt ID.

Nested handling is supported. Every successful acknowledge pushes the taken priority onto a four-entry stack. The running priority is the top of that stack, or all ones when the stack is empty. A newer candidate pre-empts only if its group priority is more urgent than the running one. The group priority is the bits of the priority above the binary point. An end-of-interrupt write pops one entry and so brings back the previous running priority. When nothing can be signalled, an acknowledge read returns the reserved ID 0x3FF and changes nothing.

A small sequencer orders the strobes. It has three states. `S_IDLE` means no strobe is due. `S_ACK` drives `ack_pulse` and `ack_id` for one cycle. `S_DEACT` drives `deact_pulse` and `deact_id` for one cycle. The sequencer evaluates the same transitions in every state:
- `take` means a qualifying acknowledge read, and leads to `S_ACK`.
- `retire` means an end-of-interrupt write while the stack is not empty, and leads to `S_DEACT`.
- Any other cycle leads to `S_IDLE`.

If a read and a write arrive in the same cycle, the write is carried out and the read has no acknowledge side effect.

Top module: `irq_cpu_port`

## Requirements
- R1: The control register at offset 0x00 resets to 0. Bit 0 enables signalling. While bit 0 is clear, `irq` is low and no acknowledge succeeds.
- R2: The mask register at offset 0x04 resets to 0. A candidate qualifies only if its priority is numerically below the mask, so every candidate is blocked after reset.
- R3: A read of offset 0x0C while a candidate qualifies returns its ID (bits 9:0, upper bits zero) in `rdata` in the cycle after `rd_en`. In that same cycle, `ack_pulse` is high for one cycle with `ack_id` equal to the ID. A read when no candidate qualifies returns 0x3FF.
- R4: While an interrupt is active, a candidate qualifies only if (priority & G) < (running & G). G is 0xFF shifted left by (binary point + 1).
- R5: Offset 0x14 reads 0xFF when nothing is active. Otherwise it reads the priority of the most recently acknowledged interrupt that is still active.
- R6: Offset 0x18 returns the candidate ID when `cand_valid` is high and 0x3FF otherwise. The read changes no state.
- R7: The binary point register at offset 0x08 is 3 bits wide and resets to 2. A write of 0 or 1 is stored as 2.
- R8: A write to offset 0x10 while an interrupt is active pulses `deact_pulse` for one cycle after the write, with `deact_id` equal to wdata[9:0]. The running priority returns to its value before the last acknowledge.
- R9: A write to offset 0x10 while nothing is active is ignored: there is no `deact_pulse`, and offset 0x14 still reads 0xFF.
- R10: An acknowledge read that returns 0x3FF has no side effect: there is no `ack_pulse` and the running priority is unchanged.
- R11: With four interrupts active, no candidate qualifies: `irq` is low and an acknowledge read returns 0x3FF.
- R12: Reads of offsets the block does not decode, and of the write-only offset 0x10, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| cand_valid | input | 1 | Distributor has a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| irq | output | 1 | Interrupt request to the processor |
| ack_pulse | output | 1 | One-cycle acknowledge strobe to the distributor |
| ack_id | output | 10 | ID that was acknowledged |
| deact_pulse | output | 1 | One-cycle deactivate strobe to the distributor |
| deact_id | output | 10 | ID that was retired |

## Verification
The hardest state to reach from the ports is a full priority stack. It needs four acknowledges in a row, and each one must carry a group priority strictly more urgent than the one before. Otherwise the pre-emption rule stops the next acknowledge before the stack fills. The bench therefore opens the mask fully and offers the candidates 0x80, 0x60, 0x40 and 0x20 in turn, acknowledging each one. It then offers 0x00 and shows that this candidate is refused. After that it retires all four and checks that the running priority unwinds in step. The binary-point grouping is reached separately: one active priority is held while the binary point is changed, so the same candidate is first allowed and then refused.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_BINPT = 8'h08;
    localparam logic [7:0] OFS_ACK   = 8'h0C;
    localparam logic [7:0] OFS_EOI   = 8'h10;
    localparam logic [7:0] OFS_RUN   = 8'h14;
    localparam logic [7:0] OFS_PEND  = 8'h18;

    localparam int BINPT_MIN = 2;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACK   = 2'd1,
        S_DEACT = 2'd2
    } port_state_e;

endpackage

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack #(
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_val,
    output logic [PRIO_W-1:0] top_val,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  level
);

    logic [PRIO_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0]  level_q;

    assign level = level_q;
    assign empty = (level_q == '0);
    assign full  = (level_q == CNT_W'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '1;
            end else if (push && !full && level_q == CNT_W'(g)) begin
                slot[g] <= push_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (push && !full) begin
            level_q <= level_q + 1'b1;
        end else if (pop && !empty) begin
            level_q <= level_q - 1'b1;
        end
    end

    always_comb begin
        top_val = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (level_q == CNT_W'(i + 1)) begin
                top_val = slot[i];
            end
        end
    end

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
    parameter int PRIO_W = 8,
    localparam int BP_W  = $clog2(PRIO_W)
) (
    input  logic              en,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] mask,
    input  logic [BP_W-1:0]   binpt,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              any_active,
    input  logic              full,
    output logic              qualify
);

    logic [PRIO_W-1:0] group_mask;
    logic              below_mask;
    logic              preempts;

    assign group_mask = {PRIO_W{1'b1}} << ({1'b0, binpt} + 1'b1);
    assign below_mask = (cand_prio < mask);
    assign preempts   = !any_active
                        || ((cand_prio & group_mask) < (run_prio & group_mask));
    assign qualify    = en && cand_valid && below_mask && preempts && !full;

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              irq,
    output logic              ack_pulse,
    output logic [ID_W-1:0]   ack_id,
    output logic              deact_pulse,
    output logic [ID_W-1:0]   deact_id
);
    import irqc_pkg::*;

    localparam int BP_W  = $clog2(PRIO_W);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ID_W-1:0] ID_NONE = {ID_W{1'b1}};
    localparam logic [BP_W-1:0] BP_MIN  = BP_W'(BINPT_MIN);

    logic              ctl_en;
    logic [PRIO_W-1:0] mask_q;
    logic [BP_W-1:0]   binpt_q;
    logic              irq_q;
    logic [31:0]       rdata_q;
    logic [31:0]       rmux;
    logic [ID_W-1:0]   ack_id_q;
    logic [ID_W-1:0]   deact_id_q;

    logic              qualify;
    logic [PRIO_W-1:0] run_prio;
    logic              empty;
    logic              full;
    logic [CNT_W-1:0]  level;

    logic              take;
    logic              retire;

    port_state_e state_q, state_d;

    irqc_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (retire),
        .push_val (cand_prio),
        .top_val  (run_prio),
        .empty    (empty),
        .full     (full),
        .level    (level)
    );

    irqc_gate #(.PRIO_W(PRIO_W)) u_gate (
        .en         (ctl_en),
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .mask       (mask_q),
        .binpt      (binpt_q),
        .run_prio   (run_prio),
        .any_active (!empty),
        .full       (full),
        .qualify    (qualify)
    );

    // Access decode
    assign take   = rd_en && !wr_en && (addr == ADDR_W'(OFS_ACK)) && qualify;
    assign retire = wr_en && (addr == ADDR_W'(OFS_EOI)) && !empty;

    // Sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sequencer: next state
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_ACK, S_DEACT: begin
                if (take) begin
                    state_d = S_ACK;
                end else if (retire) begin
                    state_d = S_DEACT;
                end else begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Sequencer: outputs
    always_comb begin
        ack_pulse   = 1'b0;
        deact_pulse = 1'b0;
        unique case (state_q)
            S_ACK:   ack_pulse   = 1'b1;
            S_DEACT: deact_pulse = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_id_q   <= '0;
            deact_id_q <= '0;
        end else begin
            if (take) begin
                ack_id_q <= cand_id;
            end
            if (retire) begin
                deact_id_q <= wdata[ID_W-1:0];
            end
        end
    end

    assign ack_id   = ack_id_q;
    assign deact_id = deact_id_q;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en  <= 1'b0;
            mask_q  <= '0;
            binpt_q <= BP_MIN;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_W'(OFS_CTRL):  ctl_en <= wdata[0];
                ADDR_W'(OFS_MASK):  mask_q <= wdata[PRIO_W-1:0];
                ADDR_W'(OFS_BINPT): binpt_q <= (wdata[BP_W-1:0] < BP_MIN)
                                              ? BP_MIN : wdata[BP_W-1:0];
                default: ;
            endcase
        end
    end

    // Read path
    always_comb begin
        rmux = '0;
        unique case (addr)
            ADDR_W'(OFS_CTRL):  rmux = {31'b0, ctl_en};
            ADDR_W'(OFS_MASK):  rmux = 32'(mask_q);
            ADDR_W'(OFS_BINPT): rmux = 32'(binpt_q);
            ADDR_W'(OFS_ACK):   rmux = 32'(take ? cand_id : ID_NONE);
            ADDR_W'(OFS_RUN):   rmux = 32'(run_prio);
            ADDR_W'(OFS_PEND):  rmux = 32'(cand_valid ? cand_id : ID_NONE);
            default:            rmux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= qualify;
            if (rd_en) begin
                rdata_q <= rmux;
            end
        end
    end

    assign rdata = rdata_q;
    assign irq   = irq_q;

endmodule

// File: rtl/irq_cpu_port_chk.sv
module irq_cpu_port_chk #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4,
    localparam int BP_W  = $clog2(PRIO_W),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              ack_pulse,
    input logic [ID_W-1:0]   ack_id,
    input logic              deact_pulse,
    input logic              ctl_en,
    input logic [BP_W-1:0]   binpt_q,
    input logic [CNT_W-1:0]  level,
    input logic [PRIO_W-1:0] run_prio,
    input logic              take
);

    p_irq_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !irq);

    p_ack_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> (rdata == 32'(ack_id)));

    p_push_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> (level == $past(level) + 1'b1));

    p_run_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (run_prio == '1));

    p_binpt_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        binpt_q >= BP_W'(2));

    p_pop_on_deact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deact_pulse |-> (level == $past(level) - 1'b1));

    p_quiet_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !take) |=> !ack_pulse);

    p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH)) |-> !take);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

endmodule

bind irq_cpu_port irq_cpu_port_chk #(
    .ID_W   (ID_W),
    .PRIO_W (PRIO_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .rdata       (rdata),
    .irq         (irq),
    .ack_pulse   (ack_pulse),
    .ack_id      (ack_id),
    .deact_pulse (deact_pulse),
    .ctl_en      (ctl_en),
    .binpt_q     (binpt_q),
    .level       (level),
    .run_prio    (run_prio),
    .take        (take)
);

// File: tb/irq_cpu_port_test.sv
module irq_cpu_port_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        irq;
    logic        ack_pulse;
    logic [9:0]  ack_id;
    logic        deact_pulse;
    logic [9:0]  deact_id;

    int n_checks = 0;
    int n_fail   = 0;

    logic        last_pulse;
    logic [9:0]  last_id;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_cpu_port uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .cand_valid  (cand_valid),
        .cand_id     (cand_id),
        .cand_prio   (cand_prio),
        .irq         (irq),
        .ack_pulse   (ack_pulse),
        .ack_id      (ack_id),
        .deact_pulse (deact_pulse),
        .deact_id    (deact_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        last_pulse = deact_pulse;
        last_id    = deact_id;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        last_pulse = ack_pulse;
        last_id    = ack_id;
    endtask

    task automatic set_cand(input logic v, input logic [9:0] id, input logic [7:0] p);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_prio = p;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", 32'(irq), 32'h0);
        reg_rd(8'h00, d); check("R1 control reset", d, 32'h0);
        reg_rd(8'h04, d); check("R2 mask reset", d, 32'h0);
        reg_rd(8'h08, d); check("R7 binary point reset", d, 32'h2);
        reg_rd(8'h14, d); check("R5 running idle", d, 32'hFF);
    endtask

    task automatic t_enable_mask();
        logic [31:0] d;
        set_cand(1'b1, 10'd33, 8'h40);
        reg_wr(8'h00, 32'h1);
        settle();
        check("R2 mask zero blocks", 32'(irq), 32'h0);
        reg_rd(8'h0C, d);
        check("R10 blocked ack id", d, 32'h3FF);
        check("R10 blocked ack no pulse", 32'(last_pulse), 32'h0);
        reg_rd(8'h14, d); check("R10 running unchanged", d, 32'hFF);
        reg_wr(8'h04, 32'h40); settle();
        check("R2 equal to mask blocks", 32'(irq), 32'h0);
        reg_wr(8'h04, 32'h41); settle();
        check("R2 below mask raises", 32'(irq), 32'h1);
        reg_wr(8'h00, 32'h0); settle();
        check("R1 disabled irq low", 32'(irq), 32'h0);
        reg_rd(8'h0C, d);
        check("R1 disabled ack refused", d, 32'h3FF);
        reg_wr(8'h00, 32'h1); settle();
        check("R1 re-enabled irq", 32'(irq), 32'h1);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        reg_rd(8'h18, d); check("R6 pending id", d, 32'd33);
        reg_rd(8'h14, d); check("R6 pending read keeps running", d, 32'hFF);
        set_cand(1'b0, 10'd33, 8'h40);
        reg_rd(8'h18, d); check("R6 no candidate", d, 32'h3FF);
    endtask

    task automatic t_binpt();
        logic [31:0] d;
        reg_wr(8'h08, 32'h0); reg_rd(8'h08, d); check("R7 write 0 clamps", d, 32'h2);
        reg_wr(8'h08, 32'h1); reg_rd(8'h08, d); check("R7 write 1 clamps", d, 32'h2);
        reg_wr(8'h08, 32'h5); reg_rd(8'h08, d); check("R7 write 5 kept", d, 32'h5);
        reg_wr(8'h08, 32'h2);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        reg_wr(8'h04, 32'hFF);
        set_cand(1'b1, 10'd33, 8'h40);
        reg_rd(8'h0C, d);
        check("R3 ack id read", d, 32'd33);
        check("R3 ack pulse", 32'(last_pulse), 32'h1);
        check("R3 ack strobe id", 32'(last_id), 32'd33);
        @(negedge clk);
        check("R3 pulse one cycle", 32'(ack_pulse), 32'h0);
        reg_rd(8'h14, d); check("R5 running after ack", d, 32'h40);
        set_cand(1'b1, 10'd34, 8'h41); settle();
        check("R4 same group blocked", 32'(irq), 32'h0);
        reg_rd(8'h0C, d); check("R4 same group ack refused", d, 32'h3FF);
        set_cand(1'b1, 10'd35, 8'h38); settle();
        check("R4 higher group raises", 32'(irq), 32'h1);
        reg_wr(8'h08, 32'h6); settle();
        check("R4 coarse binary point blocks", 32'(irq), 32'h0);
        reg_wr(8'h08, 32'h2); settle();
        reg_rd(8'h0C, d); check("R3 nested ack id", d, 32'd35);
        reg_rd(8'h14, d); check("R5 nested running", d, 32'h38);
        reg_wr(8'h10, 32'd35);
        check("R8 deact pulse", 32'(last_pulse), 32'h1);
        check("R8 deact id", 32'(last_id), 32'd35);
        reg_rd(8'h14, d); check("R8 running restored", d, 32'h40);
        reg_wr(8'h10, 32'd33);
        check("R8 second deact id", 32'(last_id), 32'd33);
        reg_rd(8'h14, d); check("R8 running idle again", d, 32'hFF);
        reg_wr(8'h10, 32'd33);
        check("R9 empty eoi no pulse", 32'(last_pulse), 32'h0);
        reg_rd(8'h14, d); check("R9 running stays idle", d, 32'hFF);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            set_cand(1'b1, 10'(100 + k), 8'(8'h80 - 8'h20 * k));
            reg_rd(8'h0C, d);
            check("R3 stack fill ack", d, 32'(100 + k));
        end
        reg_rd(8'h14, d); check("R5 deepest running", d, 32'h20);
        set_cand(1'b1, 10'd200, 8'h00); settle();
        check("R11 full irq low", 32'(irq), 32'h0);
        reg_rd(8'h0C, d); check("R11 full ack refused", d, 32'h3FF);
        check("R11 full no pulse", 32'(last_pulse), 32'h0);
        set_cand(1'b0, 10'd0, 8'h00);
        for (int k = 3; k >= 0; k--) begin
            reg_wr(8'h10, 32'(100 + k));
            check("R8 unwind id", 32'(last_id), 32'(100 + k));
            reg_rd(8'h14, d);
            check("R8 unwind running", d, (k == 0) ? 32'hFF : 32'(8'h80 - 8'h20 * (k - 1)));
        end
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        reg_rd(8'h20, d); check("R12 unmapped reads zero", d, 32'h0);
        reg_rd(8'h10, d); check("R12 eoi offset reads zero", d, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_mask();
        t_pending();
        t_binpt();
        t_nest();
        t_full();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule